// File: doc/BRIEF.md
# Triggered Frame Capture with Sync-Word Alignment

This block cuts frames out of a parallel sample stream. A sample is taken only in a cycle where its valid strobe is high. The block also watches a horizontal and a vertical sync input. While it is idle it waits for a chosen edge on one of these inputs, and that edge arms it. If a marker mask is programmed, it then searches the stream for a 16-bit marker word. The search compares only the masked bits, and it can also accept the bit-inverted pattern. If no marker turns up within a bounded number of valid samples, the block gives up and waits for a new trigger. Once aligned, it passes a programmed number of samples as one frame.

Several frames can be joined into one group. The output carries a start pulse on the first sample of the group and an end pulse on its last sample. Within a group, each later frame can either wait for its own trigger edge or begin at once after the frame before it. Configuration comes in on plain input ports. The block copies it into shadow registers only while it waits for a trigger, so a running group is never disturbed.

Top module: `fc_frame_capture`

## Requirements
- R1: `cfg_trig_vsync_i` selects the trigger input: 0 uses `hsync_i` and 1 uses `vsync_i`. Edges on the other sync input have no effect.
- R2: `cfg_trig_fall_i` selects the trigger edge: 0 is a 0-to-1 change and 1 is a 1-to-0 change, both judged against the value in the previous cycle. An edge is acted on only while the block is idle or between frames of a group. Samples in the trigger cycle and before it are never passed on.
- R3: A frame holds exactly `cfg_frame_len_i` samples, and only samples with `sample_valid_i` high are counted. Each sample taken into a frame appears on `out_data_o` with `out_valid_o` high in the cycle after its input cycle.
- R4: A group holds `cfg_group_len_i` frames, with 0 meaning a single frame. `out_sop_o` is high only with the group's first sample and `out_eop_o` only with its last. After the last sample the block returns to idle.
- R5: With `cfg_mask_i` equal to 0 there is no marker search. The frame begins with the first valid sample after the trigger.
- R6: With a nonzero mask, valid samples after the trigger are dropped until one satisfies `((sample ^ marker) & mask) == 0`. That matching sample becomes the first sample of the frame.
- R7: With `cfg_inv_ok_i` set, a sample that satisfies `((sample ^ ~marker) & mask) == 0` also matches.
- R8: With `cfg_wait_lim_i` = L, where L is not 0, L valid samples after the trigger without a match cancel the search. Nothing is output and the block is ready for a trigger in the next cycle. With L = 0 the search never gives up.
- R9: With `cfg_first_plain_i` set and `cfg_group_len_i` not 0, the first frame of a group accepts only a non-inverted match. Later frames of the group may still match the inverted pattern.
- R10: With `cfg_trig_first_only_i` clear, each later frame of a group waits for its own trigger edge and then its own marker search. With it set, the next frame's search or capture starts in the cycle after the previous frame's last sample.
- R11: Configuration inputs are sampled only while idle. Changing them after a trigger has no effect until the group ends or is cancelled.
- R12: While reset is active and right after it is released, `out_valid_o`, `out_sop_o`, `out_eop_o` and `out_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W | Input sample |
| sample_valid_i | input | 1 | Input sample qualifier |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| cfg_trig_vsync_i | input | 1 | Trigger source: 0 hsync, 1 vsync |
| cfg_trig_fall_i | input | 1 | Trigger edge: 0 rising, 1 falling |
| cfg_trig_first_only_i | input | 1 | Only the first frame of a group waits for a trigger |
| cfg_frame_len_i | input | CNT_W | Samples per frame |
| cfg_group_len_i | input | CNT_W | Frames per group, 0 = no grouping |
| cfg_wait_lim_i | input | CNT_W | Marker search limit in valid samples, 0 = unlimited |
| cfg_marker_i | input | DATA_W | Marker word |
| cfg_mask_i | input | DATA_W | Marker compare mask, 0 = no search |
| cfg_inv_ok_i | input | 1 | Also accept the inverted marker |
| cfg_first_plain_i | input | 1 | First frame of a group needs a non-inverted marker |
| out_data_o | output | DATA_W | Output sample |
| out_valid_o | output | 1 | Output sample valid |
| out_sop_o | output | 1 | First sample of a group |
| out_eop_o | output | 1 | Last sample of a group |

## Verification
Every captured sample is due on the outputs exactly one cycle after the input cycle that carried it. The bench stamps each sample it drives with its cycle index and each output it observes with the index in force just before that edge, then compares the two stamps together with the data, start and end flags. A trigger edge takes effect in its own cycle, so capture is considered from the next cycle on. A search cancelled by the limit leaves the block able to see a new edge in the cycle right after the L-th unmatched sample, and the bench model follows exactly that timing. Outputs are sampled one time unit after the rising edge, and inputs change only on falling edges.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    ST_ARM    = 2'd0,
    ST_HUNT   = 2'd1,
    ST_CAPT   = 2'd2,
    ST_RETRIG = 2'd3
  } fc_state_e;

endpackage

// File: rtl/fc_sync_edge.sv
module fc_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic sel_vsync_i,
  input  logic fall_i,
  output logic trig_o
);

  logic hs_q, vs_q;
  logic cur, prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
    end
  end

  assign cur    = sel_vsync_i ? vsync_i : hsync_i;
  assign prv    = sel_vsync_i ? vs_q : hs_q;
  assign trig_o = fall_i ? (prv & ~cur) : (cur & ~prv);

endmodule

// File: rtl/fc_marker_cmp.sv
module fc_marker_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] marker_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              inv_ok_i,
  output logic              hit_o
);

  logic [DATA_W-1:0] eq_plain, eq_inv;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign eq_plain[b] = ~mask_i[b] | (sample_i[b] == marker_i[b]);
    assign eq_inv[b]   = ~mask_i[b] | (sample_i[b] != marker_i[b]);
  end

  assign hit_o = (&eq_plain) | (inv_ok_i & (&eq_inv));

endmodule

// File: rtl/fc_counter.sv
module fc_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end

endmodule

// File: rtl/fc_frame_capture.sv
module fc_frame_capture
  import fc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              cfg_trig_vsync_i,
  input  logic              cfg_trig_fall_i,
  input  logic              cfg_trig_first_only_i,
  input  logic [CNT_W-1:0]  cfg_frame_len_i,
  input  logic [CNT_W-1:0]  cfg_group_len_i,
  input  logic [CNT_W-1:0]  cfg_wait_lim_i,
  input  logic [DATA_W-1:0] cfg_marker_i,
  input  logic [DATA_W-1:0] cfg_mask_i,
  input  logic              cfg_inv_ok_i,
  input  logic              cfg_first_plain_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  fc_state_e state_q, state_d;

  // shadow configuration, loaded only while idle
  logic              trig_vsync_q, trig_fall_q, first_only_q, inv_ok_q, first_plain_q;
  logic [CNT_W-1:0]  frame_len_q, group_len_q, wait_lim_q;
  logic [DATA_W-1:0] marker_q, mask_q;

  logic              eff_vsync, eff_fall;
  logic              trig, hit, inv_allow;
  logic              take, frame_last, group_last, timeout;
  logic              samp_clr, frame_clr, wait_clr, wait_inc;
  logic              first_q;
  logic [CNT_W-1:0]  samp_cnt, frame_cnt, wait_cnt, group_last_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_vsync_q  <= 1'b0;
      trig_fall_q   <= 1'b0;
      first_only_q  <= 1'b0;
      inv_ok_q      <= 1'b0;
      first_plain_q <= 1'b0;
      frame_len_q   <= '0;
      group_len_q   <= '0;
      wait_lim_q    <= '0;
      marker_q      <= '0;
      mask_q        <= '0;
    end else if (state_q == ST_ARM) begin
      trig_vsync_q  <= cfg_trig_vsync_i;
      trig_fall_q   <= cfg_trig_fall_i;
      first_only_q  <= cfg_trig_first_only_i;
      inv_ok_q      <= cfg_inv_ok_i;
      first_plain_q <= cfg_first_plain_i;
      frame_len_q   <= cfg_frame_len_i;
      group_len_q   <= cfg_group_len_i;
      wait_lim_q    <= cfg_wait_lim_i;
      marker_q      <= cfg_marker_i;
      mask_q        <= cfg_mask_i;
    end
  end

  // idle uses live settings; between frames uses the shadow copy
  assign eff_vsync = (state_q == ST_ARM) ? cfg_trig_vsync_i : trig_vsync_q;
  assign eff_fall  = (state_q == ST_ARM) ? cfg_trig_fall_i  : trig_fall_q;

  fc_sync_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hsync_i     (hsync_i),
    .vsync_i     (vsync_i),
    .sel_vsync_i (eff_vsync),
    .fall_i      (eff_fall),
    .trig_o      (trig)
  );

  assign inv_allow = inv_ok_q & ~(first_q & first_plain_q & (group_len_q != '0));

  fc_marker_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample_i (sample_i),
    .marker_i (marker_q),
    .mask_i   (mask_q),
    .inv_ok_i (inv_allow),
    .hit_o    (hit)
  );

  assign group_last_idx = (group_len_q == '0) ? '0 : group_len_q - CNT_ONE;

  assign take       = sample_valid_i & ((state_q == ST_CAPT) | ((state_q == ST_HUNT) & hit));
  assign frame_last = take & (samp_cnt == frame_len_q - CNT_ONE);
  assign group_last = (frame_cnt == group_last_idx);
  assign timeout    = (state_q == ST_HUNT) & sample_valid_i & ~hit &
                      (wait_lim_q != '0) & (wait_cnt == wait_lim_q - CNT_ONE);

  assign samp_clr  = (state_q == ST_ARM) | frame_last;
  assign frame_clr = (state_q == ST_ARM);
  assign wait_clr  = (state_q != ST_HUNT) | take;
  assign wait_inc  = (state_q == ST_HUNT) & sample_valid_i & ~hit;

  fc_counter #(.W(CNT_W)) u_samp_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (samp_clr),
    .inc_i  (take),
    .cnt_o  (samp_cnt)
  );

  fc_counter #(.W(CNT_W)) u_frame_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_clr),
    .inc_i  (frame_last),
    .cnt_o  (frame_cnt)
  );

  fc_counter #(.W(CNT_W)) u_wait_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wait_clr),
    .inc_i  (wait_inc),
    .cnt_o  (wait_cnt)
  );

  always_comb begin
    fc_state_e after_frame;
    after_frame = group_last ? ST_ARM : (first_only_q ? ST_HUNT : ST_RETRIG);
    state_d     = state_q;
    unique case (state_q)
      ST_ARM:    if (trig) state_d = ST_HUNT;
      ST_HUNT: begin
        if (frame_last)   state_d = after_frame;
        else if (take)    state_d = ST_CAPT;
        else if (timeout) state_d = ST_ARM;
      end
      ST_CAPT:   if (frame_last) state_d = after_frame;
      ST_RETRIG: if (trig) state_d = ST_HUNT;
      default:   state_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARM;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ARM) first_q <= 1'b1;
      else if (frame_last)   first_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_o  <= '0;
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
    end else begin
      out_valid_o <= take;
      out_sop_o   <= take & first_q & (samp_cnt == '0);
      out_eop_o   <= frame_last & group_last;
      if (take) out_data_o <= sample_i;
    end
  end

endmodule

// File: rtl/fc_capture_chk.sv
module fc_capture_chk
  import fc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input fc_state_e         state_q,
  input logic              sample_valid_i,
  input logic              out_valid_o,
  input logic              out_sop_o,
  input logic              out_eop_o,
  input logic [CNT_W-1:0]  frame_len_q,
  input logic [CNT_W-1:0]  wait_lim_q,
  input logic [CNT_W-1:0]  wait_cnt,
  input logic [DATA_W-1:0] marker_q,
  input logic [DATA_W-1:0] mask_q
);

  p_sop_in_stream_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> out_valid_o);

  p_eop_in_stream_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |-> out_valid_o);

  p_eop_rearms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |-> (state_q == ST_ARM));

  p_one_cycle_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(sample_valid_i));

  p_idle_no_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM) |=> !out_valid_o);

  p_wait_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_HUNT) && (wait_lim_q != '0)) |-> (wait_cnt < wait_lim_q));

  p_cfg_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_ARM) |=> ($stable(frame_len_q) && $stable(wait_lim_q) &&
                             $stable(marker_q) && $stable(mask_q)));

endmodule

bind fc_frame_capture fc_capture_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .state_q        (state_q),
  .sample_valid_i (sample_valid_i),
  .out_valid_o    (out_valid_o),
  .out_sop_o      (out_sop_o),
  .out_eop_o      (out_eop_o),
  .frame_len_q    (frame_len_q),
  .wait_lim_q     (wait_lim_q),
  .wait_cnt       (wait_cnt),
  .marker_q       (marker_q),
  .mask_q         (mask_q)
);

// File: tb/tb_fc_frame_capture.sv
module tb_fc_frame_capture;
  localparam int SLEN = 400;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni;
  logic [15:0] sample;
  logic        valid, hs, vs;
  logic        c_vs, c_fall, c_fo, c_inv, c_fp;
  logic [15:0] c_len, c_agg, c_lim, c_mask, c_mark, len_drv, len_alt;
  logic [15:0] out_data;
  logic        out_valid, out_sop, out_eop;
  int          alt_at;

  fc_frame_capture dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample), .sample_valid_i(valid),
    .hsync_i(hs), .vsync_i(vs),
    .cfg_trig_vsync_i(c_vs), .cfg_trig_fall_i(c_fall), .cfg_trig_first_only_i(c_fo),
    .cfg_frame_len_i(len_drv), .cfg_group_len_i(c_agg), .cfg_wait_lim_i(c_lim),
    .cfg_marker_i(c_mark), .cfg_mask_i(c_mask), .cfg_inv_ok_i(c_inv),
    .cfg_first_plain_i(c_fp),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_sop_o(out_sop), .out_eop_o(out_eop)
  );

  logic [15:0] s_a [SLEN];
  bit          v_a [SLEN];
  bit          h_a [SLEN];
  bit          y_a [SLEN];

  logic [15:0] ed[$], gd[$];
  bit          es[$], ee[$], gs[$], ge[$];
  int          ei[$], gi[$];

  int checks = 0, errors = 0, cyc = 0;
  bit mon_en = 1'b0;

  always @(posedge clk) begin
    #1;
    if (mon_en && out_valid) begin
      gd.push_back(out_data); gs.push_back(out_sop); ge.push_back(out_eop); gi.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic set_defaults();
    c_vs = 0; c_fall = 0; c_fo = 0; c_inv = 0; c_fp = 0;
    c_len = 16'd4; c_agg = 0; c_lim = 0; c_mask = 0; c_mark = 0;
    alt_at = SLEN; len_alt = 0;
  endtask

  task automatic fill_stream(input int pct);
    for (int i = 0; i < SLEN; i++) begin
      s_a[i] = 16'($urandom);
      v_a[i] = (($urandom % 100) < pct);
      h_a[i] = 0; y_a[i] = 0;
    end
  endtask

  task automatic put_pulse(input bit on_vs, input int at, input int w);
    for (int j = at; j < at + w && j < SLEN; j++) begin
      if (on_vs) y_a[j] = 1; else h_a[j] = 1;
    end
  endtask

  // reference: walks the stream as the requirements describe it
  task automatic compute_expected();
    int st, cnt, waitc, fdone, n_tot, g_tot;
    bit first, noinv, m, cur, prv, trg, fend;
    logic [15:0] l_len, l_agg, l_lim, l_mask, l_mark;
    bit l_vs, l_fall, l_fo, l_inv, l_fp;
    ed.delete(); es.delete(); ee.delete(); ei.delete();
    st = 0; cnt = 0; waitc = 0; fdone = 0; first = 0;
    l_len = 0; l_agg = 0; l_lim = 0; l_mask = 0; l_mark = 0;
    l_vs = 0; l_fall = 0; l_fo = 0; l_inv = 0; l_fp = 0;
    for (int i = 0; i < SLEN; i++) begin
      if (st == 0) begin
        l_len = (i >= alt_at) ? len_alt : c_len;
        l_agg = c_agg; l_lim = c_lim; l_mask = c_mask; l_mark = c_mark;
        l_vs = c_vs; l_fall = c_fall; l_fo = c_fo; l_inv = c_inv; l_fp = c_fp;
      end
      n_tot = (l_len == 0) ? 65536 : int'(l_len);
      g_tot = (l_agg == 0) ? 1 : int'(l_agg);
      cur = l_vs ? y_a[i] : h_a[i];
      prv = (i == 0) ? 1'b0 : (l_vs ? y_a[i-1] : h_a[i-1]);
      trg = l_fall ? (!cur && prv) : (cur && !prv);
      fend = 0;
      case (st)
        0: if (trg) begin st = 1; waitc = 0; fdone = 0; first = 1; cnt = 0; end
        3: if (trg) begin st = 1; waitc = 0; end
        1: if (v_a[i]) begin
             noinv = first && (l_agg != 0) && l_fp;
             m = (((s_a[i] ^ l_mark) & l_mask) == 16'd0) ||
                 (l_inv && !noinv && (((s_a[i] ^ ~l_mark) & l_mask) == 16'd0));
             if (m) begin
               ed.push_back(s_a[i]); es.push_back(first); ei.push_back(i);
               ee.push_back(n_tot == 1 && fdone == g_tot - 1);
               cnt = 1;
               if (cnt == n_tot) fend = 1; else st = 2;
             end else begin
               waitc++;
               if (l_lim != 0 && waitc == int'(l_lim)) st = 0;
             end
           end
        2: if (v_a[i]) begin
             cnt++;
             ed.push_back(s_a[i]); es.push_back(1'b0); ei.push_back(i);
             ee.push_back(cnt == n_tot && fdone == g_tot - 1);
             if (cnt == n_tot) fend = 1;
           end
        default: st = 0;
      endcase
      if (fend) begin
        fdone++; first = 0; cnt = 0; waitc = 0;
        if (fdone == g_tot) st = 0; else st = l_fo ? 1 : 3;
      end
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; valid = 0; hs = 0; vs = 0; sample = 0; len_drv = c_len;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic run_test(input string tag);
    int n;
    compute_expected();
    gd.delete(); gs.delete(); ge.delete(); gi.delete();
    do_reset();
    mon_en = 1;
    for (int i = 0; i < SLEN; i++) begin
      @(negedge clk);
      cyc = i;
      sample = s_a[i]; valid = v_a[i]; hs = h_a[i]; vs = y_a[i];
      len_drv = (i >= alt_at) ? len_alt : c_len;
    end
    @(negedge clk);
    cyc = SLEN; valid = 0;
    repeat (3) @(negedge clk);
    mon_en = 0;
    chk(gd.size() == ed.size(), {tag, " sample count"},
        $sformatf("%0d", gd.size()), $sformatf("%0d", ed.size()));
    n = (gd.size() < ed.size()) ? gd.size() : ed.size();
    for (int k = 0; k < n; k++) begin
      chk(gd[k] == ed[k] && gs[k] == es[k] && ge[k] == ee[k] && gi[k] == ei[k],
          $sformatf("%s item %0d", tag, k),
          $sformatf("d=%h sop=%0d eop=%0d cyc=%0d", gd[k], gs[k], ge[k], gi[k]),
          $sformatf("d=%h sop=%0d eop=%0d cyc=%0d", ed[k], es[k], ee[k], ei[k]));
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    set_defaults();
    // R12 reset state
    rst_ni = 0; valid = 0; hs = 0; vs = 0; sample = 16'hFFFF; len_drv = c_len;
    repeat (2) @(negedge clk);
    chk(out_valid == 0 && out_sop == 0 && out_eop == 0 && out_data == 0, "R12 in reset",
        $sformatf("%b%b%b %h", out_valid, out_sop, out_eop, out_data), "000 0000");
    rst_ni = 1;
    @(negedge clk);
    chk(out_valid == 0 && out_sop == 0 && out_eop == 0, "R12 after release",
        $sformatf("%b%b%b", out_valid, out_sop, out_eop), "000");

    // R1 R5 R3: hsync rising, other sync ignored, no marker
    set_defaults(); fill_stream(75); c_len = 16'd5;
    put_pulse(1, 4, 3); put_pulse(0, 10, 2);
    run_test("R1/R3/R5 hsync rise");

    // R1 R2: vsync falling edge, hsync activity ignored
    set_defaults(); fill_stream(100); c_vs = 1; c_fall = 1; c_len = 16'd6;
    put_pulse(1, 3, 6); put_pulse(0, 20, 3);
    run_test("R1/R2 vsync fall");

    // R4 R10: group of 3, next frames start at once
    set_defaults(); fill_stream(80); c_len = 16'd4; c_agg = 16'd3; c_fo = 1;
    put_pulse(0, 10, 1); put_pulse(0, 14, 1);
    run_test("R4/R10 back-to-back group");

    // R10: group of 2, each frame waits its own trigger
    set_defaults(); fill_stream(100); c_len = 16'd4; c_agg = 16'd2;
    put_pulse(0, 10, 1); put_pulse(0, 60, 1);
    run_test("R10 retrigger per frame");

    // R6 marker
    set_defaults(); fill_stream(90); c_mask = 16'hFF0F; c_mark = 16'h3C05; c_len = 16'd3;
    put_pulse(0, 10, 1); s_a[30] = 16'h3CA5; v_a[30] = 1;
    run_test("R6 marker");

    // R7 inverted marker
    set_defaults(); fill_stream(100); c_mask = 16'h0FF0; c_mark = 16'h1230; c_inv = 1;
    put_pulse(0, 10, 1); s_a[20] = (~16'h1230 & 16'h0FF0) | 16'h5005;
    run_test("R7 inverted marker");

    // R8 wait limit cancel then re-arm
    set_defaults(); fill_stream(100); c_mask = 16'hFFFF; c_mark = 16'hBEEF; c_lim = 16'd6;
    put_pulse(0, 10, 1); s_a[40] = 16'hBEEF; put_pulse(0, 60, 1); s_a[63] = 16'hBEEF;
    run_test("R8 wait limit");

    // R9 first frame ignores inverted marker
    set_defaults(); fill_stream(100); c_mask = 16'hFFFF; c_mark = 16'hA5C3;
    c_inv = 1; c_fp = 1; c_agg = 16'd2; c_fo = 1; c_len = 16'd3;
    put_pulse(0, 10, 1); s_a[15] = ~16'hA5C3; s_a[20] = 16'hA5C3; s_a[24] = ~16'hA5C3;
    run_test("R9 first plain marker");

    // R11 length change after trigger ignored until next arming
    set_defaults(); fill_stream(100); c_len = 16'd6; alt_at = 14; len_alt = 16'd3;
    put_pulse(0, 10, 1); put_pulse(0, 100, 1);
    run_test("R11 config frozen");

    // random mixes across R1 to R10
    for (int t = 0; t < 8; t++) begin
      set_defaults(); fill_stream(50 + int'($urandom % 51));
      c_vs = 1'($urandom); c_fall = 1'($urandom); c_fo = 1'($urandom);
      c_inv = 1'($urandom); c_fp = 1'($urandom);
      c_len = 16'(1 + $urandom % 8); c_agg = 16'($urandom % 4); c_lim = 16'($urandom % 12);
      c_mark = 16'($urandom);
      case ($urandom % 3)
        0: c_mask = 16'h0000;
        1: c_mask = 16'h0003;
        default: c_mask = 16'hF00F;
      endcase
      for (int p = 0; p < 5; p++) put_pulse(1'($urandom), int'($urandom % (SLEN - 20)), 1 + int'($urandom % 6));
      for (int p = 0; p < 10; p++) begin
        int pos;
        pos = int'($urandom % SLEN);
        s_a[pos] = ($urandom % 2) ? c_mark : ~c_mark;
      end
      run_test($sformatf("R1/R4/R6/R8/R10 random %0d", t));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule